// File: doc/BRIEF.md
# Handshaked Parallel Peripheral Port

This block is one eight-bit peripheral port placed between a CPU register interface and an external device. Software picks one of four operating modes with a control write. In output mode a data write drives the pins and raises READY until the device strobes. In input mode a strobe latches the pins and READY tells the device that the CPU has not yet collected the byte. In bidirectional mode (port A only) the output half drives the pins only while the device holds its strobe, and a second strobe/ready pair brings data in. In bit mode each pin is individually an input or an output, and an interrupt fires when the watched inputs meet a programmed logic condition.

All strobes are sampled on the port clock and act on their rising level change. The interrupt request is a pending flag gated by an enable bit. Any CPU data-register access clears the pending flag, unless a new event arrives in the same cycle. A parameter marks the instance as port A or port B; port B refuses the bidirectional mode.

Top module: `pioPort`

## Requirements
- R1: After reset the port is in input mode with pinOe all zero, rdy, inRdy and intReq low, and interrupts disabled.
- R2: A control write (cpuSel=1) whose low nibble is 4'hF is a mode word, with the mode in bits 7:6: 0 output, 1 input, 2 bidirectional, 3 bit mode. A mode word clears rdy, inRdy and the pending interrupt.
- R3: In output mode a data write (cpuSel=0) shows the byte on pinOut, with pinOe all ones, and rdy is high from the clock edge of the write on. A rising stb while rdy is high clears rdy and sets the pending interrupt.
- R4: In input mode a rising stb while rdy is low latches pinIn and sets rdy and the pending interrupt. A CPU data read returns the latched byte and clears rdy. A strobe while rdy is high is ignored and keeps the held byte.
- R5: In bidirectional mode pinOe is all ones exactly while stb is high, and all zero otherwise. Output data and rdy behave as in R3. A rising inStb while inRdy is low latches pinIn, sets inRdy and sets the pending interrupt. A data read clears inRdy.
- R6: An instance built with PORT_A=0 ignores a mode word that asks for the bidirectional mode and keeps its previous mode.
- R7: In bit mode the control write that follows the mode word loads the direction mask (1 = input). pinOe is the inverse of that mask, rdy and inRdy stay low, and a data read returns pin values for input bits and the output register for output bits.
- R8: A control write with low nibble 4'h7 is an interrupt word: bit 7 enable, bit 6 AND (1) or OR (0), bit 5 active-high (1) or active-low (0), and bit 4 says the next control write loads the match mask. In bit mode, when the watched input bits (match mask AND direction mask) start to meet the condition, the pending interrupt is set.
- R9: intReq is high only while the pending flag and the enable bit are both set. A CPU data read or write clears the pending flag.
- R10: When a completing event and a CPU data access fall in the same cycle, the event wins: the pending flag is set, and in input mode rdy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | CPU write strobe, one cycle |
| cpuRe | input | 1 | CPU read strobe, one cycle |
| cpuSel | input | 1 | 0 selects the data register, 1 the control register |
| cpuWdata | input | DATA_W | CPU write data |
| cpuRdata | output | DATA_W | CPU read data for the data register |
| pinIn | input | DATA_W | Values seen on the peripheral pins |
| pinOut | output | DATA_W | Values driven onto the peripheral pins |
| pinOe | output | DATA_W | Per-pin output enable |
| stb | input | 1 | Peripheral strobe, active high |
| rdy | output | 1 | Ready to the peripheral |
| inStb | input | 1 | Input-half strobe in bidirectional mode |
| inRdy | output | 1 | Input-half ready in bidirectional mode |
| intReq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are a handshake completion, which sets the pending interrupt and READY, and a CPU data access, which clears both. The bench provokes this in input mode by raising stb, with new pin data, on the same clock edge as a CPU data read. In the following cycle it expects rdy and intReq both high, and a later read must return the newly latched byte. The same pending flag is also checked to fall after a plain access with no event.

// File: rtl/pioPkg.sv
package pioPkg;
  typedef enum logic [1:0] {
    MODE_OUT   = 2'd0,
    MODE_IN    = 2'd1,
    MODE_BIDIR = 2'd2,
    MODE_BIT   = 2'd3
  } pioMode_e;

  typedef struct packed {
    logic loadOut;
    logic captureIn;
  } pioStrobe_t;

  localparam logic [3:0] MODE_TAG = 4'hF;
  localparam logic [3:0] INT_TAG  = 4'h7;
endpackage

// File: rtl/pioCtrl.sv
module pioCtrl
  import pioPkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit PORT_A = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic              cpuSel,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              stb,
  input  logic              inStb,
  input  logic              matchHit,
  output pioMode_e          mode,
  output logic [DATA_W-1:0] dirMask,
  output logic [DATA_W-1:0] matchMask,
  output logic              andSel,
  output logic              highSel,
  output pioStrobe_t        strb,
  output logic              rdy,
  output logic              inRdy,
  output logic              intReq
);
  logic stbQ, inStbQ, matchQ, intPend, intEn, expectDir, expectMask;
  logic dataWr, ctrlWr, dataRd, stbRise, inStbRise;
  logic modeWord, intWord, modeOk, outDone, matchEvt, setPend;
  pioMode_e reqMode;

  assign dataWr    = cpuWe & ~cpuSel;
  assign ctrlWr    = cpuWe & cpuSel;
  assign dataRd    = cpuRe & ~cpuSel;
  assign stbRise   = stb & ~stbQ;
  assign inStbRise = inStb & ~inStbQ;
  assign reqMode   = pioMode_e'(cpuWdata[7:6]);
  assign modeOk    = PORT_A || (reqMode != MODE_BIDIR);
  assign modeWord  = ctrlWr && !expectDir && !expectMask
                     && (cpuWdata[3:0] == MODE_TAG) && modeOk;
  assign intWord   = ctrlWr && !expectDir && !expectMask
                     && (cpuWdata[3:0] == INT_TAG);

  assign strb.loadOut   = dataWr && (mode != MODE_IN);
  assign strb.captureIn = ((mode == MODE_IN) && stbRise && !rdy)
                       || ((mode == MODE_BIDIR) && inStbRise && !inRdy);
  assign outDone  = ((mode == MODE_OUT) || (mode == MODE_BIDIR)) && stbRise && rdy;
  assign matchEvt = (mode == MODE_BIT) && matchHit && !matchQ;
  assign setPend  = strb.captureIn || outDone || matchEvt;
  assign intReq   = intPend & intEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbQ <= 1'b0; inStbQ <= 1'b0; matchQ <= 1'b0;
      mode <= MODE_IN; dirMask <= '1; matchMask <= '0;
      andSel <= 1'b0; highSel <= 1'b0; intEn <= 1'b0;
      expectDir <= 1'b0; expectMask <= 1'b0;
      rdy <= 1'b0; inRdy <= 1'b0; intPend <= 1'b0;
    end else begin
      stbQ   <= stb;
      inStbQ <= inStb;
      matchQ <= (mode == MODE_BIT) && matchHit;
      if (ctrlWr && expectDir) begin
        dirMask   <= cpuWdata;
        expectDir <= 1'b0;
      end else if (ctrlWr && expectMask) begin
        matchMask  <= cpuWdata;
        expectMask <= 1'b0;
      end
      if (intWord) begin
        intEn      <= cpuWdata[7];
        andSel     <= cpuWdata[6];
        highSel    <= cpuWdata[5];
        expectMask <= cpuWdata[4];
      end
      if (modeWord) begin
        mode      <= reqMode;
        expectDir <= (reqMode == MODE_BIT);
        rdy <= 1'b0; inRdy <= 1'b0; intPend <= 1'b0;
      end else begin
        case (mode)
          MODE_OUT, MODE_BIDIR: begin
            if (strb.loadOut) rdy <= 1'b1;
            else if (stbRise) rdy <= 1'b0;
          end
          MODE_IN: begin
            if (strb.captureIn) rdy <= 1'b1;
            else if (dataRd)    rdy <= 1'b0;
          end
          default: rdy <= 1'b0;
        endcase
        if (mode == MODE_BIDIR) begin
          if (strb.captureIn) inRdy <= 1'b1;
          else if (dataRd)    inRdy <= 1'b0;
        end else begin
          inRdy <= 1'b0;
        end
        if (setPend)               intPend <= 1'b1;
        else if (dataRd || dataWr) intPend <= 1'b0;
      end
    end
  end

  // R3: a data write in output mode leaves READY high afterwards
  a_r3_rdy_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OUT && dataWr) |=> rdy);
  // R9: an access without a new event drops the pending flag
  a_r9_access_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((dataRd || dataWr) && !setPend) |=> !intPend);
  // R10: a capture beats a simultaneous read
  a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IN && stbRise && !rdy && dataRd) |=> (rdy && intPend));
  // R7: bit mode carries no handshake
  a_r7_bit_no_handshake: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BIT) |-> (!rdy && !inRdy));

  generate
    if (!PORT_A) begin : gPortB
      // R6: port B never enters the bidirectional mode
      a_r6_no_bidir_on_b: assert property (@(posedge clk) disable iff (!rstN)
        mode != MODE_BIDIR);
    end
  endgenerate
endmodule

// File: rtl/pioData.sv
module pioData
  import pioPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioMode_e          mode,
  input  logic [DATA_W-1:0] dirMask,
  input  logic [DATA_W-1:0] matchMask,
  input  logic              andSel,
  input  logic              highSel,
  input  pioStrobe_t        strb,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] pinIn,
  input  logic              stb,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              matchHit
);
  logic [DATA_W-1:0] outReg, inReg, bitHit, watched, hits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
      inReg  <= '0;
    end else begin
      if (strb.loadOut)   outReg <= cpuWdata;
      if (strb.captureIn) inReg  <= pinIn;
    end
  end

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : gBit
      assign bitHit[i] = highSel ? pinIn[i] : ~pinIn[i];
    end
  endgenerate

  assign watched  = matchMask & dirMask;
  assign hits     = bitHit & watched;
  assign matchHit = andSel ? ((watched != '0) && (hits == watched)) : (hits != '0);
  assign pinOut   = outReg;

  always_comb begin
    case (mode)
      MODE_OUT:   pinOe = '1;
      MODE_IN:    pinOe = '0;
      MODE_BIDIR: pinOe = {DATA_W{stb}};
      default:    pinOe = ~dirMask;
    endcase
    case (mode)
      MODE_OUT:            cpuRdata = outReg;
      MODE_IN, MODE_BIDIR: cpuRdata = inReg;
      default:             cpuRdata = (pinIn & dirMask) | (outReg & ~dirMask);
    endcase
  end

  // R5: bidirectional pins float whenever the strobe is low
  a_r5_float_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BIDIR && !stb) |-> (pinOe == '0));
  // R7: no pin marked as input is driven in bit mode
  a_r7_inputs_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BIT) |-> ((pinOe & dirMask) == '0));
endmodule

// File: rtl/pioPort.sv
module pioPort
  import pioPkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit PORT_A = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic              cpuSel,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  input  logic              stb,
  output logic              rdy,
  input  logic              inStb,
  output logic              inRdy,
  output logic              intReq
);
  pioMode_e          mode;
  pioStrobe_t        strb;
  logic [DATA_W-1:0] dirMask, matchMask;
  logic              andSel, highSel, matchHit;

  pioCtrl #(.DATA_W(DATA_W), .PORT_A(PORT_A)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuSel(cpuSel),
    .cpuWdata(cpuWdata), .stb(stb), .inStb(inStb), .matchHit(matchHit),
    .mode(mode), .dirMask(dirMask), .matchMask(matchMask), .andSel(andSel),
    .highSel(highSel), .strb(strb), .rdy(rdy), .inRdy(inRdy), .intReq(intReq)
  );

  pioData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .mode(mode), .dirMask(dirMask),
    .matchMask(matchMask), .andSel(andSel), .highSel(highSel), .strb(strb),
    .cpuWdata(cpuWdata), .pinIn(pinIn), .stb(stb), .pinOut(pinOut),
    .pinOe(pinOe), .cpuRdata(cpuRdata), .matchHit(matchHit)
  );
endmodule

// File: tb/tb_pioPort.sv
module tb_pioPort;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWe = 1'b0, cpuRe = 1'b0, cpuSel = 1'b0, bWe = 1'b0;
  logic [7:0] cpuWdata = '0, pinIn = '0;
  logic       stb = 1'b0, inStb = 1'b0;
  logic [7:0] cpuRdata, pinOut, pinOe;
  logic       rdy, inRdy, intReq;
  logic [7:0] bRdata, bPinOut, bPinOe;
  logic       bRdy, bInRdy, bIntReq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pioPort #(.DATA_W(8), .PORT_A(1'b1)) dut (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuSel(cpuSel),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .stb(stb), .rdy(rdy), .inStb(inStb), .inRdy(inRdy),
    .intReq(intReq)
  );

  pioPort #(.DATA_W(8), .PORT_A(1'b0)) dutB (
    .clk(clk), .rstN(rstN), .cpuWe(bWe), .cpuRe(1'b0), .cpuSel(cpuSel),
    .cpuWdata(cpuWdata), .cpuRdata(bRdata), .pinIn(pinIn), .pinOut(bPinOut),
    .pinOe(bPinOe), .stb(stb), .rdy(bRdy), .inStb(inStb), .inRdy(bInRdy),
    .intReq(bIntReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    tick(); cpuWe = 1'b1; cpuSel = sel; cpuWdata = d;
    tick(); cpuWe = 1'b0; cpuSel = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    tick(); cpuRe = 1'b1; cpuSel = 1'b0;
    #1 d = cpuRdata;
    tick(); cpuRe = 1'b0;
  endtask

  task automatic pulse();
    tick(); stb = 1'b1;
    tick(); stb = 1'b0;
    tick();
  endtask

  task automatic testReset();
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 rdy", {7'd0, rdy}, 8'h00);
    check("R1 inRdy", {7'd0, inRdy}, 8'h00);
    check("R1 intReq", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testOutput();
    wr(1'b1, 8'b1000_0111);   // R8 enable, OR, active low
    wr(1'b1, 8'b0000_1111);   // R2 output mode
    check("R2 output oe", pinOe, 8'hFF);
    wr(1'b0, 8'hA5);
    check("R3 pinOut", pinOut, 8'hA5);
    check("R3 rdy after write", {7'd0, rdy}, 8'h01);
    tick(); stb = 1'b1; tick();
    check("R3 rdy cleared", {7'd0, rdy}, 8'h00);
    check("R3 intReq", {7'd0, intReq}, 8'h01);
    stb = 1'b0;
    wr(1'b0, 8'h3C);
    check("R9 write clears", {7'd0, intReq}, 8'h00);
    check("R3 rdy again", {7'd0, rdy}, 8'h01);
  endtask

  task automatic testInput();
    logic [7:0] d;
    wr(1'b1, 8'b0100_1111);
    check("R2 input rdy", {7'd0, rdy}, 8'h00);
    check("R2 input oe", pinOe, 8'h00);
    pinIn = 8'h5A; pulse();
    check("R4 rdy set", {7'd0, rdy}, 8'h01);
    check("R4 intReq", {7'd0, intReq}, 8'h01);
    pinIn = 8'h11; pulse();
    rd(d);
    check("R4 held byte", d, 8'h5A);
    check("R4 rdy cleared", {7'd0, rdy}, 8'h00);
    check("R9 read clears", {7'd0, intReq}, 8'h00);
    // R10 collision: strobe edge and read on the same clock
    tick(); pinIn = 8'h77; stb = 1'b1; cpuRe = 1'b1; cpuSel = 1'b0;
    tick(); cpuRe = 1'b0;
    check("R10 rdy wins", {7'd0, rdy}, 8'h01);
    check("R10 pend wins", {7'd0, intReq}, 8'h01);
    stb = 1'b0;
    rd(d);
    check("R10 new byte", d, 8'h77);
    wr(1'b1, 8'b0000_0111);   // R9 disable
    pinIn = 8'h22; pulse();
    check("R9 gated", {7'd0, intReq}, 8'h00);
    check("R9 rdy still", {7'd0, rdy}, 8'h01);
    rd(d);
    check("R4 read 22", d, 8'h22);
    wr(1'b1, 8'b1000_0111);
  endtask

  task automatic testBidir();
    logic [7:0] d;
    wr(1'b1, 8'b1000_1111);
    check("R5 float", pinOe, 8'h00);
    wr(1'b0, 8'hC3);
    check("R5 rdy", {7'd0, rdy}, 8'h01);
    check("R5 still float", pinOe, 8'h00);
    tick(); stb = 1'b1; tick();
    check("R5 drive", pinOe, 8'hFF);
    check("R5 pinOut", pinOut, 8'hC3);
    check("R5 rdy clr", {7'd0, rdy}, 8'h00);
    check("R5 intReq", {7'd0, intReq}, 8'h01);
    stb = 1'b0; tick();
    check("R5 float after", pinOe, 8'h00);
    rd(d);
    pinIn = 8'h99;
    tick(); inStb = 1'b1; tick(); inStb = 1'b0;
    check("R5 inRdy", {7'd0, inRdy}, 8'h01);
    check("R5 in int", {7'd0, intReq}, 8'h01);
    rd(d);
    check("R5 in byte", d, 8'h99);
    check("R5 inRdy clr", {7'd0, inRdy}, 8'h00);
  endtask

  task automatic testPortB();
    tick(); bWe = 1'b1; cpuSel = 1'b1; cpuWdata = 8'b1000_1111;
    tick(); bWe = 1'b0; cpuSel = 1'b0;
    pinIn = 8'h44; stb = 1'b1; tick();
    check("R6 B still input oe", bPinOe, 8'h00);
    check("R6 B captured", {7'd0, bRdy}, 8'h01);
    stb = 1'b0; tick();
  endtask

  task automatic testBitMode();
    logic [7:0] d;
    wr(1'b1, 8'b1100_1111);
    wr(1'b1, 8'hF0);          // R7 direction mask
    check("R7 oe", pinOe, 8'h0F);
    check("R7 rdy", {7'd0, rdy}, 8'h00);
    wr(1'b0, 8'h05);
    check("R7 pinOut", {4'd0, pinOut[3:0]}, 8'h05);
    wr(1'b1, 8'b1111_0111);   // R8 en, AND, high, mask follows
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h05);          // clears any pending
    pinIn = 8'h10; tick(); tick();
    check("R8 AND partial", {7'd0, intReq}, 8'h00);
    pinIn = 8'h30; tick(); tick();
    check("R8 AND match", {7'd0, intReq}, 8'h01);
    rd(d);
    check("R7 mixed read", d, 8'h35);
    check("R9 match cleared", {7'd0, intReq}, 8'h00);
    wr(1'b1, 8'b1000_0111);   // R8 en, OR, active low
    tick(); tick();
    check("R8 OR none", {7'd0, intReq}, 8'h00);
    pinIn = 8'h20; tick(); tick();
    check("R8 OR low match", {7'd0, intReq}, 8'h01);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testOutput();
    testInput();
    testBidir();
    testPortB();
    testBitMode();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule